// File: doc/BRIEF.md
# Memory Request Address Decoder

This block sits between a system-side request port and an external memory queue. It takes one read or write request, described by a byte address, a transfer count, a transfer size and a wrap flag, and turns it into one or two external memory bursts. Each burst carries the chip it targets, the bank, row and column fields, its own start address, a beat count and a flag that marks the final burst of the request.

The target chip is found by a masked compare of the top address byte against four programmable match values. The address is then scaled down to memory words according to the memory data width. It is cut into column, row and bank fields whose widths come from global configuration. The order of the bank and row fields is chosen per chip. A wrapping request that does not start on its wrap boundary is emitted as two incrementing bursts. Configuration is held static on input pins, and both sides use a valid/ready handshake. A request is captured in the cycle it is accepted, and its first burst is offered on the next cycle.

Top module: `mem_req_decoder`

## Requirements
- R1: Chip i (0..3) matches when `((in_addr[31:24] ^ cfg_match[8i+7:8i]) & ~cfg_mask[8i+7:8i]) == 0`, so a mask bit of 1 marks a don't-care position. When several chips match, the lowest-numbered one is chosen and `out_no_match` is 0.
- R2: A request that matches no chip is still emitted, with `out_chip` = 0 and `out_no_match` = 1.
- R3: The memory word address is the byte address shifted right by 0, 1 or 2 for `cfg_width` codes 0, 1 and 2 (1-, 2- and 4-byte memory). Code 3 acts as 2. The column is the low C bits of the word address, with C = 8 + `cfg_col_bits` for codes 0..4. Higher codes act as 4.
- R4: When `cfg_brc[chip]` = 1, the fields run from high to low as bank, row, column. The row is the R bits above the column, and the bank is the 2 bits above the row.
- R5: When `cfg_brc[chip]` = 0, the fields run from high to low as row, bank, column. The bank is the 2 bits above the column, and the row is the R bits above the bank.
- R6: The row width is R = 11 + `cfg_row_bits` for codes 0..5. Higher codes act as 5. Word-address bits above the row field do not appear in `out_row`.
- R7: For an incrementing request, the byte total is `(in_len+1) << in_size`. `out_beats` is that total shifted right by min(`in_size`, width code), and `out_last` = 1.
- R8: A wrapping request whose address is not aligned to its byte total produces two bursts. The first starts at the request address and covers the bytes up to the wrap boundary, with `out_last` = 0. The second starts at the aligned wrap base and covers the remaining bytes, with `out_last` = 1. Beat counts use the same shift as R7.
- R9: A wrapping request whose address is aligned to its byte total produces a single burst, identical to the incrementing case.
- R10: After reset, `out_valid` = 0 and `in_ready` = 1. While `out_valid` = 1 and `out_ready` = 0, every output stays unchanged. `in_ready` is 0 while a non-final burst is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be accepted |
| in_addr | input | 32 | Request byte address |
| in_len | input | 4 | Transfers in the request minus one |
| in_size | input | 3 | Log2 of bytes per transfer |
| in_wrap | input | 1 | 1 for a wrapping request |
| cfg_match | input | 32 | Match byte for each chip, chip i in bits 8i+7:8i |
| cfg_mask | input | 32 | Don't-care mask for each chip, same layout |
| cfg_brc | input | 4 | Per-chip field order, 1 = bank-row-column |
| cfg_row_bits | input | 3 | Row width code |
| cfg_col_bits | input | 3 | Column width code |
| cfg_width | input | 2 | Memory data width code |
| out_valid | output | 1 | Burst valid |
| out_ready | input | 1 | Burst accepted by the consumer |
| out_chip | output | 2 | Selected chip |
| out_no_match | output | 1 | No chip matched |
| out_bank | output | 2 | Bank field |
| out_row | output | 16 | Row field |
| out_col | output | 12 | Column field |
| out_addr | output | 32 | Burst start byte address |
| out_beats | output | 12 | Memory beats in this burst |
| out_last | output | 1 | Final burst of the request |

## Verification
The only state is the captured request, a busy bit and a phase bit that picks the first or second half of a split wrap. All decoding is combinational from those registers.

A wrongly captured field shows as a wrong chip, row, column or beat count on the first cycle that `out_valid` rises. A phase or busy fault shows within one handshake: a missing or duplicated second burst, a wrong `out_last`, or `in_ready` held at the wrong level.

Stalls with `out_ready` low show whether the held burst drifts. Requests placed at and just off a wrap boundary, plus addresses that hit zero, one and several chips, show whether the split and priority logic behave correctly.

// File: rtl/mem_req_decoder.sv
module mem_req_decoder #(
  parameter int ADDR_W  = 32,
  parameter int LEN_W   = 4,
  parameter int NCHIP   = 4,
  parameter int ROW_MAX = 16,
  parameter int COL_MAX = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [ADDR_W-1:0]        in_addr,
  input  logic [LEN_W-1:0]         in_len,
  input  logic [2:0]               in_size,
  input  logic                     in_wrap,
  input  logic [8*NCHIP-1:0]       cfg_match,
  input  logic [8*NCHIP-1:0]       cfg_mask,
  input  logic [NCHIP-1:0]         cfg_brc,
  input  logic [2:0]               cfg_row_bits,
  input  logic [2:0]               cfg_col_bits,
  input  logic [1:0]               cfg_width,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [$clog2(NCHIP)-1:0] out_chip,
  output logic                     out_no_match,
  output logic [1:0]               out_bank,
  output logic [ROW_MAX-1:0]       out_row,
  output logic [COL_MAX-1:0]       out_col,
  output logic [ADDR_W-1:0]        out_addr,
  output logic [LEN_W+7:0]         out_beats,
  output logic                     out_last
);
  localparam int CHIP_W  = $clog2(NCHIP);
  localparam int BYTES_W = LEN_W + 8;

  logic              busy, phase;
  logic [ADDR_W-1:0] r_addr;
  logic [LEN_W-1:0]  r_len;
  logic [2:0]        r_size;
  logic              r_wrap;

  logic [BYTES_W-1:0] total, p_bytes, offs_b;
  logic [ADDR_W-1:0]  wbase, offs, word, colmask, rowmask, t_row, t_bank;
  logic               split;
  logic [1:0]         wlog;
  logic [2:0]         ulog, ccode, rcode;
  logic [4:0]         colw, roww;
  logic [7:0]         top;
  logic               sel_brc;

  assign total   = (BYTES_W'(r_len) + 1'b1) << r_size;
  assign wbase   = r_addr & ~(ADDR_W'(total) - 1'b1);
  assign offs    = r_addr - wbase;
  assign offs_b  = offs[BYTES_W-1:0];
  assign split   = r_wrap && (offs != '0);
  assign out_last = !split || phase;
  assign out_addr = phase ? wbase : r_addr;
  assign p_bytes = !split ? total : (phase ? offs_b : total - offs_b);

  assign wlog = (cfg_width > 2'd2) ? 2'd2 : cfg_width;
  assign ulog = (r_size < {1'b0, wlog}) ? r_size : {1'b0, wlog};
  assign out_beats = p_bytes >> ulog;

  assign top = out_addr[ADDR_W-1 -: 8];
  always_comb begin
    out_chip     = '0;
    out_no_match = 1'b1;
    for (int i = NCHIP - 1; i >= 0; i--) begin
      if (((top ^ cfg_match[8*i +: 8]) & ~cfg_mask[8*i +: 8]) == 8'd0) begin
        out_chip     = CHIP_W'(i);
        out_no_match = 1'b0;
      end
    end
  end

  assign ccode   = (cfg_col_bits > 3'd4) ? 3'd4 : cfg_col_bits;
  assign rcode   = (cfg_row_bits > 3'd5) ? 3'd5 : cfg_row_bits;
  assign colw    = 5'd8 + {2'b0, ccode};
  assign roww    = 5'd11 + {2'b0, rcode};
  assign colmask = (ADDR_W'(1) << colw) - 1'b1;
  assign rowmask = (ADDR_W'(1) << roww) - 1'b1;
  assign word    = out_addr >> wlog;
  assign sel_brc = cfg_brc[out_chip];

  always_comb begin
    if (sel_brc) begin
      t_row  = (word >> colw) & rowmask;
      t_bank = word >> (colw + roww);
    end else begin
      t_bank = word >> colw;
      t_row  = (word >> (colw + 5'd2)) & rowmask;
    end
  end

  logic [ADDR_W-1:0] t_col;
  assign t_col    = word & colmask;
  assign out_col  = t_col[COL_MAX-1:0];
  assign out_row  = t_row[ROW_MAX-1:0];
  assign out_bank = t_bank[1:0];

  assign out_valid = busy;
  assign in_ready  = !busy || (out_ready && out_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      phase  <= 1'b0;
      r_addr <= '0;
      r_len  <= '0;
      r_size <= '0;
      r_wrap <= 1'b0;
    end else if (in_valid && in_ready) begin
      busy   <= 1'b1;
      phase  <= 1'b0;
      r_addr <= in_addr;
      r_len  <= in_len;
      r_size <= in_size;
      r_wrap <= in_wrap;
    end else if (out_valid && out_ready) begin
      if (out_last) busy  <= 1'b0;
      else          phase <= 1'b1;
    end
  end
endmodule

// File: rtl/mem_req_decoder_chk.sv
module mem_req_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [31:0] in_addr,
  input logic [3:0]  in_len,
  input logic [2:0]  in_size,
  input logic        in_wrap,
  input logic [31:0] cfg_match,
  input logic [31:0] cfg_mask,
  input logic [3:0]  cfg_brc,
  input logic [2:0]  cfg_row_bits,
  input logic [2:0]  cfg_col_bits,
  input logic [1:0]  cfg_width,
  input logic        out_valid,
  input logic        out_ready,
  input logic [1:0]  out_chip,
  input logic        out_no_match,
  input logic [1:0]  out_bank,
  input logic [15:0] out_row,
  input logic [11:0] out_col,
  input logic [31:0] out_addr,
  input logic [11:0] out_beats,
  input logic        out_last
);
  logic [7:0] sel_m, sel_k;
  assign sel_m = cfg_match[8*out_chip +: 8];
  assign sel_k = cfg_mask[8*out_chip +: 8];

  assert_hit_matches_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_no_match |-> ((out_addr[31:24] ^ sel_m) & ~sel_k) == 8'd0);

  assert_miss_chip0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_no_match |-> out_chip == 2'd0);

  assert_col_narrow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && cfg_col_bits == 3'd0 |-> out_col[11:8] == 4'd0);

  assert_beats_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_beats != 12'd0);

  assert_second_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !out_last |=> out_valid && out_last);

  assert_hold_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_beats)
      && $stable(out_last) && $stable(out_chip));

  assert_block_midsplit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_last |-> !in_ready);
endmodule

bind mem_req_decoder mem_req_decoder_chk u_chk (.*);

// File: tb/mem_req_decoder_tb.sv
module mem_req_decoder_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready, in_wrap = 0, out_valid, out_ready = 0;
  logic out_no_match, out_last;
  logic [31:0] in_addr = 0, cfg_match = 0, cfg_mask = 32'hFFFF_FFFF, out_addr;
  logic [3:0]  in_len = 0, cfg_brc = 4'hF;
  logic [2:0]  in_size = 0, cfg_row_bits = 0, cfg_col_bits = 0;
  logic [1:0]  cfg_width = 2, out_chip, out_bank;
  logic [15:0] out_row;
  logic [11:0] out_col, out_beats;

  int n_cmp = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_req_decoder u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic issue(input logic [31:0] a, input logic [3:0] l, input logic [2:0] s, input logic w);
    @(negedge clk);
    in_addr = a; in_len = l; in_size = s; in_wrap = w; in_valid = 1; out_ready = 0;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic take;
    out_ready = 1;
    @(negedge clk);
    out_ready = 0;
  endtask

  task automatic t_reset;
    chk("R10 reset out_valid", out_valid, 0);
    chk("R10 reset in_ready", in_ready, 1);
  endtask

  task automatic t_chip_select;
    cfg_match = 32'h80_40_40_10; cfg_mask = 32'h7F_00_0F_00;
    issue(32'h4512_3400, 0, 2, 0);
    chk("R1 masked hit chip", out_chip, 1); chk("R1 no_match", out_no_match, 0); take();
    issue(32'h4000_0000, 0, 2, 0);
    chk("R1 lowest wins", out_chip, 1); take();
    issue(32'h8F00_0000, 0, 2, 0);
    chk("R1 msb-only mask", out_chip, 3); take();
    issue(32'h2000_0000, 0, 2, 0);
    chk("R2 miss valid", out_valid, 1); chk("R2 miss chip", out_chip, 0);
    chk("R2 miss flag", out_no_match, 1); take();
    cfg_match = 0; cfg_mask = 32'hFFFF_FFFF;
  endtask

  task automatic t_column;
    cfg_width = 2; cfg_col_bits = 0; cfg_row_bits = 0; cfg_brc = 4'hF;
    issue(32'h0000_0ABC, 0, 2, 0);
    chk("R3 col 8b w4", out_col, 12'h0AF); take();
    cfg_width = 0; cfg_col_bits = 4;
    issue(32'h0000_0ABC, 0, 0, 0);
    chk("R3 col 12b w1", out_col, 12'hABC); take();
    cfg_width = 2; cfg_col_bits = 0;
  endtask

  task automatic t_order;
    cfg_brc = 4'hF;
    issue(32'h0044_8D14, 0, 2, 0);
    chk("R4 bank", out_bank, 2); chk("R4 row", out_row, 16'h123); chk("R4 col", out_col, 12'h45); take();
    cfg_brc = 4'hE;
    issue(32'h0044_8D14, 0, 2, 0);
    chk("R5 bank", out_bank, 3); chk("R5 row", out_row, 16'h448); chk("R5 col", out_col, 12'h45); take();
    cfg_brc = 4'hF;
  endtask

  task automatic t_row_width;
    cfg_row_bits = 5;
    issue(32'h06FB_BC48, 0, 2, 0);
    chk("R6 row 16b", out_row, 16'hBEEF); chk("R6 bank 16b", out_bank, 1); take();
    cfg_row_bits = 0;
    issue(32'h06FB_BC48, 0, 2, 0);
    chk("R6 row 11b", out_row, 16'h6EF); chk("R6 bank 11b", out_bank, 3); take();
  endtask

  task automatic t_incr_beats;
    cfg_width = 2;
    issue(32'h0000_0100, 3, 3, 0);
    chk("R7 wide beats", out_beats, 8); chk("R7 last", out_last, 1); take();
    issue(32'h0000_0100, 7, 0, 0);
    chk("R7 narrow beats", out_beats, 8); take();
    cfg_width = 1;
    issue(32'h0000_0100, 0, 1, 0);
    chk("R7 half beats", out_beats, 1); take();
    cfg_width = 2;
  endtask

  task automatic t_wrap;
    issue(32'h0000_1008, 3, 2, 1);
    chk("R8 p1 addr", out_addr, 32'h1008); chk("R8 p1 beats", out_beats, 2);
    chk("R8 p1 last", out_last, 0);
    @(negedge clk);
    chk("R10 stall hold addr", out_addr, 32'h1008); chk("R10 in_ready low", in_ready, 0);
    take();
    chk("R8 p2 valid", out_valid, 1); chk("R8 p2 addr", out_addr, 32'h1000);
    chk("R8 p2 beats", out_beats, 2); chk("R8 p2 last", out_last, 1); take();
    chk("R8 done", out_valid, 0);
    issue(32'h0000_100C, 3, 2, 1);
    chk("R8 b p1 beats", out_beats, 1); take();
    chk("R8 b p2 addr", out_addr, 32'h1000); chk("R8 b p2 beats", out_beats, 3); take();
    issue(32'h0000_1000, 3, 2, 1);
    chk("R9 aligned beats", out_beats, 4); chk("R9 aligned last", out_last, 1); take();
    chk("R9 single burst", out_valid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog got=hung exp=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_chip_select();
    t_column();
    t_order();
    t_row_width();
    t_incr_beats();
    t_wrap();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule